// File: doc/BRIEF.md
# Single-Price Coin Vendor Controller

This controller sequences a coin-fed dispenser for one item priced at 25 cents. Each clock it may see one-cycle pulses from three coin sensors (5, 10 and 25 cents) and from a cancel button. It records the deposit as one of five credit levels, from 0 to 20 cents, in a one-hot state register.

When a coin brings the deposit to the price or above it, the controller enters a dispense state for one clock. No change is given, so any excess is kept. If cancel is pressed while credit is held, it enters a refund state for one clock. After either state it returns to zero credit.

Both outputs are decoded from the state alone, so each is a clean one-clock pulse. The pulse appears in the cycle after the clock edge that sampled the deciding input.

Top module: `vend_ctrl`

## Requirements
- R1: While rst_ni is low, and right after it rises, the credit is zero and vend_o and refund_o are both 0.
- R2: A nickel adds 5 cents, a dime 10 and a quarter 25. When a coin brings the credit to 25 cents or more, vend_o is 1 for exactly the one cycle after the edge that sampled that coin.
- R3: Overpayment is kept. After a dispense the credit is zero, so a further full 25 cents is needed for the next dispense.
- R4: If cancel_i is sampled while the credit is 5 to 20 cents, refund_o is 1 for exactly the next cycle and the credit then becomes zero.
- R5: If cancel_i is sampled at zero credit, it has no effect: refund_o stays 0 and the credit stays zero.
- R6: When several inputs pulse in the same cycle, only the highest-priority one acts. The order is cancel_i, then quarter_i, then dime_i, then nickel_i.
- R7: Every input sampled during a dispense or refund cycle is ignored, and the next cycle is zero credit with both outputs 0.
- R8: vend_o and refund_o are never 1 together, and each depends only on the state register.
- R9: Exactly one bit of the seven-bit state register is set in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nickel_i | input | 1 | One-cycle pulse for a 5-cent coin |
| dime_i | input | 1 | One-cycle pulse for a 10-cent coin |
| quarter_i | input | 1 | One-cycle pulse for a 25-cent coin |
| cancel_i | input | 1 | One-cycle pulse for the coin-return button |
| vend_o | output | 1 | Dispense pulse |
| refund_o | output | 1 | Refund pulse |

## Verification
From reset, every sequence of three cycles is applied, where each cycle takes any of the 16 combinations of the four input pulses. Each sequence is followed by five nickels, which reveal the remaining credit through the cycle on which the dispense pulse appears. A bench model in cents predicts both outputs on every cycle. The sweep covers all of the following:
- every credit level reached by every coin mix, which separates correct summing from wrong coin weights;
- overpayment that is discarded rather than carried over;
- simultaneous pulses, which expose a wrong priority order;
- pulses landing on a dispense or refund cycle, which must be ignored.

Directed cases cover cancel at zero credit, which must not refund, and the reset state.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int unsigned ADD_W = 4;

  typedef struct packed {
    logic             cancel;
    logic [ADD_W-1:0] add;
  } coin_sel_t;
endpackage

// File: rtl/vend_coin_sel.sv
module vend_coin_sel
  import vend_pkg::*;
#(
  parameter int unsigned NICKEL_U  = 1,
  parameter int unsigned DIME_U    = 2,
  parameter int unsigned QUARTER_U = 5
) (
  input  logic      nickel_i,
  input  logic      dime_i,
  input  logic      quarter_i,
  input  logic      cancel_i,
  output coin_sel_t sel_o
);
  localparam logic [ADD_W-1:0] N_ADD = ADD_W'(NICKEL_U);
  localparam logic [ADD_W-1:0] D_ADD = ADD_W'(DIME_U);
  localparam logic [ADD_W-1:0] Q_ADD = ADD_W'(QUARTER_U);

  // priority: cancel > quarter > dime > nickel
  always_comb begin
    sel_o.cancel = cancel_i;
    sel_o.add    = '0;
    if (!cancel_i) begin
      if (quarter_i)     sel_o.add = Q_ADD;
      else if (dime_i)   sel_o.add = D_ADD;
      else if (nickel_i) sel_o.add = N_ADD;
    end
  end
endmodule

// File: rtl/vend_credit_step.sv
module vend_credit_step
  import vend_pkg::*;
#(
  parameter int unsigned N_CREDIT = 5
) (
  input  logic [N_CREDIT-1:0] cur_i,
  input  logic [ADD_W-1:0]    add_i,
  output logic [N_CREDIT-1:0] nxt_o,
  output logic                reach_o
);
  always_comb begin
    nxt_o   = '0;
    reach_o = 1'b0;
    for (int k = 0; k < int'(N_CREDIT); k++) begin
      if (cur_i[k] && (k + int'(add_i) >= int'(N_CREDIT))) reach_o = 1'b1;
      for (int j = 0; j < int'(N_CREDIT); j++) begin
        if (cur_i[k] && (k + int'(add_i) == j)) nxt_o[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int unsigned UNIT_CENTS    = 5,
  parameter int unsigned PRICE_CENTS   = 25,
  parameter int unsigned NICKEL_CENTS  = 5,
  parameter int unsigned DIME_CENTS    = 10,
  parameter int unsigned QUARTER_CENTS = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nickel_i,
  input  logic dime_i,
  input  logic quarter_i,
  input  logic cancel_i,
  output logic vend_o,
  output logic refund_o
);
  localparam int unsigned N_CREDIT = PRICE_CENTS / UNIT_CENTS;
  localparam int unsigned ST_VEND  = N_CREDIT;
  localparam int unsigned ST_REF   = N_CREDIT + 1;
  localparam int unsigned NUM_ST   = N_CREDIT + 2;
  localparam logic [NUM_ST-1:0] ST_ZERO = NUM_ST'(1);

  logic [NUM_ST-1:0]   state_q, state_d;
  logic [N_CREDIT-1:0] credit_nxt;
  logic                reach;
  logic                busy;
  coin_sel_t           sel;

  vend_coin_sel #(
    .NICKEL_U (NICKEL_CENTS / UNIT_CENTS),
    .DIME_U   (DIME_CENTS / UNIT_CENTS),
    .QUARTER_U(QUARTER_CENTS / UNIT_CENTS)
  ) i_sel (
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .quarter_i(quarter_i),
    .cancel_i (cancel_i),
    .sel_o    (sel)
  );

  vend_credit_step #(.N_CREDIT(N_CREDIT)) i_step (
    .cur_i  (state_q[N_CREDIT-1:0]),
    .add_i  (sel.add),
    .nxt_o  (credit_nxt),
    .reach_o(reach)
  );

  assign busy = state_q[ST_VEND] | state_q[ST_REF];

  always_comb begin
    state_d = ST_ZERO;
    if (busy || (state_q == '0)) begin
      state_d = ST_ZERO;  // outputs last one cycle; inputs dropped
    end else if (sel.cancel) begin
      if (!state_q[0]) begin
        state_d = '0;
        state_d[ST_REF] = 1'b1;
      end
    end else if (reach) begin
      state_d = '0;
      state_d[ST_VEND] = 1'b1;
    end else begin
      state_d = {2'b00, credit_nxt};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ZERO;
    else         state_q <= state_d;
  end

  assign vend_o   = state_q[ST_VEND];
  assign refund_o = state_q[ST_REF];
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int unsigned NUM_ST = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              quarter_i,
  input logic              cancel_i,
  input logic              vend_o,
  input logic              refund_o,
  input logic [NUM_ST-1:0] state_q
);
  a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q) == 1);

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vend_o && refund_o));

  a_r2_vend_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vend_o |=> (!vend_o && state_q[0]));

  a_r4_refund: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vend_o && !refund_o && !state_q[0] && cancel_i) |=> refund_o);

  a_r5_zero_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q[0] && cancel_i) |=> (state_q[0] && !refund_o));

  a_r7_refund_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refund_o |=> (state_q[0] && !refund_o && !vend_o));

  a_r6_quarter_vends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vend_o && !refund_o && quarter_i && !cancel_i) |=> vend_o);
endmodule

bind vend_ctrl vend_ctrl_chk #(.NUM_ST(NUM_ST)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .quarter_i(quarter_i),
  .cancel_i (cancel_i),
  .vend_o   (vend_o),
  .refund_o (refund_o),
  .state_q  (state_q)
);

// File: tb/test_vend_ctrl.sv
module test_vend_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic nickel, dime, quarter, cancel;
  logic vend, refund;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // model state
  int m_credit = 0;
  int m_phase = 0;  // 0 credit, 1 dispense, 2 refund

  always #2 clk = ~clk;  // 250 MHz

  vend_ctrl i_vend_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .nickel_i(nickel), .dime_i(dime), .quarter_i(quarter), .cancel_i(cancel),
    .vend_o(vend), .refund_o(refund)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // b = {cancel, quarter, dime, nickel}
  task automatic step(input logic [3:0] b, input string tag_v, input string tag_r);
    @(negedge clk);
    {cancel, quarter, dime, nickel} = b;
    @(posedge clk);
    if (m_phase != 0) begin
      m_phase = 0; m_credit = 0;
    end else if (b[3]) begin
      if (m_credit > 0) begin m_phase = 2; m_credit = 0; end
    end else begin
      m_credit += b[2] ? 25 : b[1] ? 10 : b[0] ? 5 : 0;
      if (m_credit >= 25) begin m_phase = 1; m_credit = 0; end
    end
    #1;
    chk(tag_v, vend, m_phase == 1);
    chk(tag_r, refund, m_phase == 2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    {cancel, quarter, dime, nickel} = 4'b0;
    #1;
    chk("R1 vend in reset", vend, 1'b0);
    chk("R1 refund in reset", refund, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    m_credit = 0; m_phase = 0;
  endtask

  initial begin
    {cancel, quarter, dime, nickel} = 4'b0;
    do_reset();
    // R1: zero credit after reset, 5 nickels -> dispense on 5th
    for (int i = 0; i < 5; i++) step(4'b0001, "R1 R2 vend", "R1 refund");
    chk("R1 credit zero after reset", vend, 1'b1);

    // R3: 20 + dime overpays; next dispense needs full 25
    do_reset();
    for (int i = 0; i < 4; i++) step(4'b0001, "R3 vend", "R3 refund");
    step(4'b0010, "R3 vend", "R3 refund");
    chk("R3 overpay dispenses", vend, 1'b1);
    step(4'b0000, "R3 vend", "R3 refund");
    for (int i = 0; i < 4; i++) step(4'b0001, "R3 vend", "R3 refund");
    chk("R3 excess discarded", vend, 1'b0);
    step(4'b0001, "R3 vend", "R3 refund");
    chk("R3 full price again", vend, 1'b1);

    // R5: cancel at zero credit
    do_reset();
    step(4'b1000, "R5 vend", "R5 refund");
    chk("R5 no refund at zero", refund, 1'b0);

    // R6: cancel beats quarter at credit 5
    step(4'b0001, "R6 vend", "R6 refund");
    step(4'b1100, "R6 vend", "R6 refund");
    chk("R6 cancel wins", refund, 1'b1);
    // R6: dime beats nickel -> 10; three nickels dispense on the third
    step(4'b0000, "R6 vend", "R6 refund");
    step(4'b0011, "R6 vend", "R6 refund");
    step(4'b0001, "R6 vend", "R6 refund");
    step(4'b0001, "R6 vend", "R6 refund");
    chk("R6 dime over nickel", vend, 1'b0);
    step(4'b0001, "R6 vend", "R6 refund");
    chk("R6 dime over nickel", vend, 1'b1);

    // R7: quarter during dispense ignored
    step(4'b0100, "R7 vend", "R7 refund");
    chk("R7 quarter ignored", vend, 1'b0);

    // sweep: all 3-cycle input sequences, then 5 nickel probes
    for (int s = 0; s < 4096; s++) begin
      do_reset();
      for (int i = 0; i < 3; i++) step(4'((s >> (4 * i)) & 15), "R2 R6 R7 vend", "R4 R6 R7 refund");
      for (int p = 0; p < 5; p++) step(4'b0001, "R3 R7 probe vend", "R8 probe refund");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule